// File: doc/BRIEF.md
# Locking Priority Command Stream Arbiter

This block lets two independent command-stream producers share one SPI execution engine. Each upstream port carries four valid/ready channels: a 16-bit command channel, a write-data channel toward the engine, a read-data channel from the engine, and an 8-bit synchronization-acknowledge channel from the engine. A single registered grant steers all four channels at once. The non-owner port is fully isolated, so a transaction made of several commands reaches the engine as one unbroken group.

Arbitration uses a fixed priority, and port 0 outranks port 1. A port that wins keeps the engine until it issues a synchronization command and the engine's acknowledge for it has been handed back upstream. The controller is a three-state machine:

- `ARB_IDLE` forwards nothing. It takes transition *grant* to `ARB_LOCKED` when any command valid is high, and the lowest requesting index is recorded as owner.
- `ARB_LOCKED` forwards the owner's commands and data. It takes transition *sync_sent* to `ARB_DRAIN` when a synchronization command from the owner is accepted downstream.
- `ARB_DRAIN` still routes data and acknowledges but accepts no further commands. It takes transition *release* back to `ARB_IDLE` when the acknowledge handshake completes on the owner's upstream channel.

Top module: `cmd_stream_arbiter`

## Requirements
- R1: After a synchronous active-low reset, no port is granted: every upstream ready and valid output is 0, and every downstream valid and ready output is 0.
- R2: When both ports raise command valid in an idle cycle, port 0 receives the grant in the next cycle.
- R3: The grant is registered. In the idle cycle in which a request is first seen, no command is forwarded and no upstream command ready is raised.
- R4: While a port owns the grant, the other port's command ready stays 0 and its commands are not forwarded, even when the other port is port 0.
- R5: A command is a synchronization command only when bits [15:12] equal 4'b0011 and bit 8 is 1. Any other command, including one that matches only one of these two fields, leaves the grant unchanged.
- R6: After the owner's synchronization command is accepted downstream, no further command from any port is accepted. The grant is held until a cycle in which the downstream acknowledge valid and the owner's acknowledge ready are both 1.
- R7: The cycle after the acknowledge handshake is idle, with nothing forwarded. Arbitration then runs again, and port 0 wins again if it is requesting.
- R8: The downstream write-data valid and data come only from the owner. The non-owner's write-data ready is 0.
- R9: Read data and acknowledges (valid and data) reach only the owner. The non-owner sees 0 on those outputs, and the downstream read and acknowledge readies follow the owner only.
- R10: Write data is DATA_W bits wide. Read data is DATA_W × SDI_LANES bits wide (default 8 × 1). Acknowledge data is 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_cmd_valid | input | 2 | Command valid per port |
| up_cmd_ready | output | 2 | Command ready per port |
| up_cmd_data | input | 2×16 | Command word per port |
| up_sdo_valid | input | 2 | Write-data valid per port |
| up_sdo_ready | output | 2 | Write-data ready per port |
| up_sdo_data | input | 2×DATA_W | Write data per port |
| up_sdi_valid | output | 2 | Read-data valid per port |
| up_sdi_ready | input | 2 | Read-data ready per port |
| up_sdi_data | output | 2×(DATA_W·SDI_LANES) | Read data per port |
| up_sync_valid | output | 2 | Acknowledge valid per port |
| up_sync_ready | input | 2 | Acknowledge ready per port |
| up_sync_data | output | 2×8 | Acknowledge id per port |
| m_cmd_valid | output | 1 | Command valid to engine |
| m_cmd_ready | input | 1 | Command ready from engine |
| m_cmd_data | output | 16 | Command word to engine |
| m_sdo_valid | output | 1 | Write-data valid to engine |
| m_sdo_ready | input | 1 | Write-data ready from engine |
| m_sdo_data | output | DATA_W | Write data to engine |
| m_sdi_valid | input | 1 | Read-data valid from engine |
| m_sdi_ready | output | 1 | Read-data ready to engine |
| m_sdi_data | input | DATA_W·SDI_LANES | Read data from engine |
| m_sync_valid | input | 1 | Acknowledge valid from engine |
| m_sync_ready | output | 1 | Acknowledge ready to engine |
| m_sync_data | input | 8 | Acknowledge id from engine |

## Verification
The hardest situation to reach is port 1 holding the engine while port 0, the higher-priority port, is requesting, with the acknowledge then delayed. Random traffic rarely gets there, because port 0 almost always wins.

The stimulus therefore raises port 1's request alone, waits for the grant, and only then raises port 0. Port 1 sends two near-miss commands that must not count as synchronization, then a real one. The bench holds back the acknowledge for several cycles, and then offers it once without upstream ready, so that the release is seen to wait for the full handshake. A long random phase follows, compared cycle by cycle against a behavioural model.

// File: rtl/cmd_arb_pkg.sv
package cmd_arb_pkg;
    localparam int NPORT   = 2;
    localparam int OWN_W   = $clog2(NPORT);
    localparam int CMD_W   = 16;
    localparam int SYNC_W  = 8;

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_LOCKED = 2'd1,
        ARB_DRAIN  = 2'd2
    } arb_state_e;

    function automatic logic is_sync_cmd(input logic [CMD_W-1:0] c);
        return (c[15:12] == 4'b0011) && c[8];
    endfunction
endpackage

// File: rtl/cmd_arb_fsm.sv
module cmd_arb_fsm
    import cmd_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req,
    input  logic             sync_taken,
    input  logic             ack_done,
    output arb_state_e       state,
    output logic [OWN_W-1:0] owner
);
    arb_state_e       state_nxt;
    logic [OWN_W-1:0] owner_nxt;
    logic [OWN_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (req[i]) pick = OWN_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_IDLE;
            owner <= '0;
        end else begin
            state <= state_nxt;
            owner <= owner_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        owner_nxt = owner;
        unique case (state)
            ARB_IDLE: begin
                if (|req) begin
                    state_nxt = ARB_LOCKED;
                    owner_nxt = pick;
                end
            end
            ARB_LOCKED: begin
                if (sync_taken) state_nxt = ARB_DRAIN;
            end
            ARB_DRAIN: begin
                if (ack_done) state_nxt = ARB_IDLE;
            end
            default: state_nxt = ARB_IDLE;
        endcase
    end

    assert_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && req[0]) |=> (state == ARB_LOCKED && owner == '0));

    assert_hold_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ARB_IDLE) |=> (state == ARB_IDLE || owner == $past(owner)));

    assert_stay_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_LOCKED && !sync_taken) |=> (state == ARB_LOCKED));

    assert_wait_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_DRAIN && !ack_done) |=> (state == ARB_DRAIN));

    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_DRAIN && ack_done) |=> (state == ARB_IDLE));
endmodule

// File: rtl/cmd_arb_route.sv
module cmd_arb_route
    import cmd_arb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SDI_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  arb_state_e                        state,
    input  logic [OWN_W-1:0]                  owner,
    input  logic [NPORT-1:0]                  up_cmd_valid,
    output logic [NPORT-1:0]                  up_cmd_ready,
    input  logic [NPORT-1:0][CMD_W-1:0]       up_cmd_data,
    input  logic [NPORT-1:0]                  up_sdo_valid,
    output logic [NPORT-1:0]                  up_sdo_ready,
    input  logic [NPORT-1:0][DATA_W-1:0]      up_sdo_data,
    output logic [NPORT-1:0]                  up_sdi_valid,
    input  logic [NPORT-1:0]                  up_sdi_ready,
    output logic [NPORT-1:0][SDI_W-1:0]       up_sdi_data,
    output logic [NPORT-1:0]                  up_sync_valid,
    input  logic [NPORT-1:0]                  up_sync_ready,
    output logic [NPORT-1:0][SYNC_W-1:0]      up_sync_data,
    output logic                              m_cmd_valid,
    input  logic                              m_cmd_ready,
    output logic [CMD_W-1:0]                  m_cmd_data,
    output logic                              m_sdo_valid,
    input  logic                              m_sdo_ready,
    output logic [DATA_W-1:0]                 m_sdo_data,
    input  logic                              m_sdi_valid,
    output logic                              m_sdi_ready,
    input  logic [SDI_W-1:0]                  m_sdi_data,
    input  logic                              m_sync_valid,
    output logic                              m_sync_ready,
    input  logic [SYNC_W-1:0]                 m_sync_data
);
    logic fwd_cmd;
    logic fwd_data;

    assign fwd_cmd  = (state == ARB_LOCKED);
    assign fwd_data = (state != ARB_IDLE);

    always_comb begin
        m_cmd_valid  = 1'b0;
        m_cmd_data   = '0;
        m_sdo_valid  = 1'b0;
        m_sdo_data   = '0;
        m_sdi_ready  = 1'b0;
        m_sync_ready = 1'b0;
        if (fwd_cmd) begin
            m_cmd_valid = up_cmd_valid[owner];
            m_cmd_data  = up_cmd_data[owner];
        end
        if (fwd_data) begin
            m_sdo_valid  = up_sdo_valid[owner];
            m_sdo_data   = up_sdo_data[owner];
            m_sdi_ready  = up_sdi_ready[owner];
            m_sync_ready = up_sync_ready[owner];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic sel;
        assign sel              = fwd_data && (owner == OWN_W'(p));
        assign up_cmd_ready[p]  = fwd_cmd && sel && m_cmd_ready;
        assign up_sdo_ready[p]  = sel && m_sdo_ready;
        assign up_sdi_valid[p]  = sel && m_sdi_valid;
        assign up_sdi_data[p]   = sel ? m_sdi_data : '0;
        assign up_sync_valid[p] = sel && m_sync_valid;
        assign up_sync_data[p]  = sel ? m_sync_data : '0;
    end

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE) |-> (!m_cmd_valid && up_cmd_ready == '0 && up_sync_valid == '0));

    assert_drain_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_DRAIN) |-> (up_cmd_ready == '0 && !m_cmd_valid));

    assert_single_sink_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(up_sdi_valid) && $onehot0(up_sync_valid));
endmodule

// File: rtl/cmd_stream_arbiter.sv
module cmd_stream_arbiter
    import cmd_arb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SDI_LANES = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NPORT-1:0]                       up_cmd_valid,
    output logic [NPORT-1:0]                       up_cmd_ready,
    input  logic [NPORT-1:0][CMD_W-1:0]            up_cmd_data,
    input  logic [NPORT-1:0]                       up_sdo_valid,
    output logic [NPORT-1:0]                       up_sdo_ready,
    input  logic [NPORT-1:0][DATA_W-1:0]           up_sdo_data,
    output logic [NPORT-1:0]                       up_sdi_valid,
    input  logic [NPORT-1:0]                       up_sdi_ready,
    output logic [NPORT-1:0][DATA_W*SDI_LANES-1:0] up_sdi_data,
    output logic [NPORT-1:0]                       up_sync_valid,
    input  logic [NPORT-1:0]                       up_sync_ready,
    output logic [NPORT-1:0][SYNC_W-1:0]           up_sync_data,
    output logic                                   m_cmd_valid,
    input  logic                                   m_cmd_ready,
    output logic [CMD_W-1:0]                       m_cmd_data,
    output logic                                   m_sdo_valid,
    input  logic                                   m_sdo_ready,
    output logic [DATA_W-1:0]                      m_sdo_data,
    input  logic                                   m_sdi_valid,
    output logic                                   m_sdi_ready,
    input  logic [DATA_W*SDI_LANES-1:0]            m_sdi_data,
    input  logic                                   m_sync_valid,
    output logic                                   m_sync_ready,
    input  logic [SYNC_W-1:0]                      m_sync_data
);
    localparam int SDI_W = DATA_W * SDI_LANES;

    arb_state_e       state;
    logic [OWN_W-1:0] owner;
    logic             sync_taken;
    logic             ack_done;

    assign sync_taken = m_cmd_valid && m_cmd_ready && is_sync_cmd(m_cmd_data);
    assign ack_done   = m_sync_valid && m_sync_ready;

    cmd_arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (up_cmd_valid),
        .sync_taken (sync_taken),
        .ack_done   (ack_done),
        .state      (state),
        .owner      (owner)
    );

    cmd_arb_route #(.DATA_W(DATA_W), .SDI_W(SDI_W)) u_route (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .owner         (owner),
        .up_cmd_valid  (up_cmd_valid),
        .up_cmd_ready  (up_cmd_ready),
        .up_cmd_data   (up_cmd_data),
        .up_sdo_valid  (up_sdo_valid),
        .up_sdo_ready  (up_sdo_ready),
        .up_sdo_data   (up_sdo_data),
        .up_sdi_valid  (up_sdi_valid),
        .up_sdi_ready  (up_sdi_ready),
        .up_sdi_data   (up_sdi_data),
        .up_sync_valid (up_sync_valid),
        .up_sync_ready (up_sync_ready),
        .up_sync_data  (up_sync_data),
        .m_cmd_valid   (m_cmd_valid),
        .m_cmd_ready   (m_cmd_ready),
        .m_cmd_data    (m_cmd_data),
        .m_sdo_valid   (m_sdo_valid),
        .m_sdo_ready   (m_sdo_ready),
        .m_sdo_data    (m_sdo_data),
        .m_sdi_valid   (m_sdi_valid),
        .m_sdi_ready   (m_sdi_ready),
        .m_sdi_data    (m_sdi_data),
        .m_sync_valid  (m_sync_valid),
        .m_sync_ready  (m_sync_ready),
        .m_sync_data   (m_sync_data)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (up_cmd_ready == '0 && !m_sdo_valid && !m_sdi_ready && !m_sync_ready));
endmodule

// File: tb/tb_cmd_stream_arbiter.sv
module tb_cmd_stream_arbiter;
    localparam int DW = 8;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]         up_cmd_valid, up_cmd_ready;
    logic [1:0][15:0]   up_cmd_data;
    logic [1:0]         up_sdo_valid, up_sdo_ready;
    logic [1:0][DW-1:0] up_sdo_data;
    logic [1:0]         up_sdi_valid, up_sdi_ready;
    logic [1:0][SW-1:0] up_sdi_data;
    logic [1:0]         up_sync_valid, up_sync_ready;
    logic [1:0][7:0]    up_sync_data;
    logic               m_cmd_valid, m_cmd_ready;
    logic [15:0]        m_cmd_data;
    logic               m_sdo_valid, m_sdo_ready;
    logic [DW-1:0]      m_sdo_data;
    logic               m_sdi_valid, m_sdi_ready;
    logic [SW-1:0]      m_sdi_data;
    logic               m_sync_valid, m_sync_ready;
    logic [7:0]         m_sync_data;

    cmd_stream_arbiter #(.DATA_W(DW), .SDI_LANES(1)) dut (.*);

    int total = 0;
    int bad = 0;
    int mst = 0;   // model: 0 idle, 1 owned, 2 waiting for acknowledge
    int mo = 0;    // model owner
    bit finished = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare all outputs against the model, then advance one clock
    task automatic step();
        logic e_mcv; logic [15:0] e_mcd; logic [1:0] e_ucr;
        logic e_msv; logic [DW-1:0] e_msd; logic [1:0] e_usr;
        logic [1:0] e_usiv; logic [1:0][SW-1:0] e_usid; logic e_msir;
        logic [1:0] e_usyv; logic [1:0][7:0] e_usyd; logic e_msyr;
        int nst; int no;
        #1;
        e_mcv = 0; e_mcd = '0; e_ucr = '0; e_msv = 0; e_msd = '0; e_usr = '0;
        e_usiv = '0; e_usid = '0; e_msir = 0; e_usyv = '0; e_usyd = '0; e_msyr = 0;
        if (rst_n && mst == 1) begin
            e_mcv = up_cmd_valid[mo];
            e_mcd = up_cmd_data[mo];
            e_ucr[mo] = m_cmd_ready;
        end
        if (rst_n && mst != 0) begin
            e_msv = up_sdo_valid[mo];  e_msd = up_sdo_data[mo];
            e_usr[mo] = m_sdo_ready;
            e_usiv[mo] = m_sdi_valid;  e_usid[mo] = m_sdi_data;
            e_msir = up_sdi_ready[mo];
            e_usyv[mo] = m_sync_valid; e_usyd[mo] = m_sync_data;
            e_msyr = up_sync_ready[mo];
        end
        if (rst_n) begin
            chk("R4", "m_cmd_valid", 64'(m_cmd_valid), 64'(e_mcv));
            chk("R4", "m_cmd_data", 64'(m_cmd_data), 64'(e_mcd));
            chk("R4", "up_cmd_ready", 64'(up_cmd_ready), 64'(e_ucr));
            chk("R8", "m_sdo_valid", 64'(m_sdo_valid), 64'(e_msv));
            chk("R8", "m_sdo_data", 64'(m_sdo_data), 64'(e_msd));
            chk("R8", "up_sdo_ready", 64'(up_sdo_ready), 64'(e_usr));
            chk("R9", "up_sdi_valid", 64'(up_sdi_valid), 64'(e_usiv));
            chk("R9", "up_sdi_data", 64'(up_sdi_data), 64'(e_usid));
            chk("R9", "m_sdi_ready", 64'(m_sdi_ready), 64'(e_msir));
            chk("R9", "up_sync_valid", 64'(up_sync_valid), 64'(e_usyv));
            chk("R9", "up_sync_data", 64'(up_sync_data), 64'(e_usyd));
            chk("R9", "m_sync_ready", 64'(m_sync_ready), 64'(e_msyr));
        end
        nst = mst; no = mo;
        if (!rst_n) begin
            nst = 0; no = 0;
        end else if (mst == 0) begin
            if (up_cmd_valid[0]) begin nst = 1; no = 0; end
            else if (up_cmd_valid[1]) begin nst = 1; no = 1; end
        end else if (mst == 1) begin
            if (up_cmd_valid[mo] && m_cmd_ready &&
                up_cmd_data[mo][15:12] == 4'h3 && up_cmd_data[mo][8]) nst = 2;
        end else begin
            if (m_sync_valid && up_sync_ready[mo]) nst = 0;
        end
        @(posedge clk);
        #1;
        mst = nst; mo = no;
    endtask

    task automatic clear_inputs();
        up_cmd_valid = '0; up_cmd_data = '0; up_sdo_valid = '0; up_sdo_data = '0;
        up_sdi_ready = '0; up_sync_ready = '0;
        m_cmd_ready = 0; m_sdo_ready = 0; m_sdi_valid = 0; m_sdi_data = '0;
        m_sync_valid = 0; m_sync_data = '0;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        rst_n = 0;
        repeat (3) step();
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1", "up_cmd_ready", 64'(up_cmd_ready), 0);
        chk("R1", "m_cmd_valid", 64'(m_cmd_valid), 0);
        chk("R1", "m_sync_ready", 64'(m_sync_ready), 0);
        chk("R1", "up_sync_valid", 64'(up_sync_valid), 0);
        step();

        // simultaneous requests
        up_cmd_valid = 2'b11; up_cmd_data[0] = 16'h1001; up_cmd_data[1] = 16'h2002;
        m_cmd_ready = 1;
        #1;
        chk("R3", "m_cmd_valid in request cycle", 64'(m_cmd_valid), 0);
        chk("R3", "up_cmd_ready in request cycle", 64'(up_cmd_ready), 0);
        step();
        chk("R2", "up_cmd_ready after tie", 64'(up_cmd_ready), 64'(2'b01));
        chk("R2", "m_cmd_data after tie", 64'(m_cmd_data), 64'h1001);
        up_cmd_data[0] = 16'h31AA;
        step();
        chk("R6", "up_cmd_ready waiting ack", 64'(up_cmd_ready), 0);
        m_sync_valid = 1; m_sync_data = 8'hAA; up_sync_ready = 2'b11;
        #1;
        chk("R9", "up_sync_valid to owner", 64'(up_sync_valid), 64'(2'b01));
        chk("R9", "up_sync_data to owner", 64'(up_sync_data), 64'h00AA);
        step();
        m_sync_valid = 0; up_sync_ready = '0;
        up_cmd_data[0] = 16'h1003;
        #1;
        chk("R7", "m_cmd_valid idle gap", 64'(m_cmd_valid), 0);
        step();
        chk("R7", "up_cmd_ready port0 wins again", 64'(up_cmd_ready), 64'(2'b01));
        up_cmd_data[0] = 16'h31BB;
        step();
        up_cmd_valid = '0; m_sync_valid = 1; up_sync_ready = 2'b01;
        step();
        clear_inputs();
        step();

        // port 1 owns while port 0 requests
        up_cmd_valid = 2'b10; up_cmd_data[1] = 16'h3001; m_cmd_ready = 1;
        step();
        up_cmd_valid = 2'b11; up_cmd_data[0] = 16'h1111;
        up_sdo_valid = 2'b11; up_sdo_data[0] = 8'h11; up_sdo_data[1] = 8'h22; m_sdo_ready = 1;
        m_sdi_valid = 1; m_sdi_data = 8'h5A; up_sdi_ready = 2'b11;
        #1;
        chk("R4", "up_cmd_ready port1 owns", 64'(up_cmd_ready), 64'(2'b10));
        chk("R8", "m_sdo_data from owner", 64'(m_sdo_data), 64'h22);
        chk("R8", "up_sdo_ready owner only", 64'(up_sdo_ready), 64'(2'b10));
        chk("R9", "up_sdi_valid owner only", 64'(up_sdi_valid), 64'(2'b10));
        chk("R9", "up_sdi_data non-owner", 64'(up_sdi_data[0]), 0);
        chk("R10", "up_sdi_data owner width", 64'(up_sdi_data[1]), 64'h5A);
        step();
        chk("R5", "nibble-only match keeps grant", 64'(up_cmd_ready), 64'(2'b10));
        up_cmd_data[1] = 16'h5100;
        step();
        chk("R5", "bit8-only match keeps grant", 64'(up_cmd_ready), 64'(2'b10));
        up_cmd_data[1] = 16'h3142;
        step();
        for (int k = 0; k < 3; k++) begin
            chk("R6", "up_cmd_ready before ack", 64'(up_cmd_ready), 0);
            chk("R6", "m_cmd_valid before ack", 64'(m_cmd_valid), 0);
            step();
        end
        m_sync_valid = 1; m_sync_data = 8'h42; up_sync_ready = 2'b00;
        step();
        chk("R6", "no release without upstream ready", 64'(up_cmd_ready), 0);
        chk("R9", "up_sync_data to port1", 64'(up_sync_data), 64'h4200);
        up_sync_ready = 2'b10;
        step();
        m_sync_valid = 0;
        #1;
        chk("R7", "idle after ack", 64'(m_cmd_valid), 0);
        step();
        chk("R7", "port0 granted after release", 64'(up_cmd_ready), 64'(2'b01));
        clear_inputs();
        up_cmd_valid = 2'b01; up_cmd_data[0] = 16'h3100; m_cmd_ready = 1;
        step();
        up_cmd_valid = '0; m_sync_valid = 1; up_sync_ready = 2'b01;
        step();
        clear_inputs();
        step();

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < 2; p++) begin
                up_cmd_valid[p] = ($urandom % 4) != 0;
                if ($urandom % 5 == 0)
                    up_cmd_data[p] = {4'h3, 3'($urandom), 1'b1, 8'($urandom)};
                else
                    up_cmd_data[p] = 16'($urandom);
                up_sdo_valid[p] = 1'($urandom);
                up_sdo_data[p] = 8'($urandom);
                up_sdi_ready[p] = 1'($urandom);
                up_sync_ready[p] = 1'($urandom);
            end
            m_cmd_ready = 1'($urandom); m_sdo_ready = 1'($urandom);
            m_sdi_valid = 1'($urandom); m_sdi_data = 8'($urandom);
            m_sync_valid = ($urandom % 3) == 0; m_sync_data = 8'($urandom);
            step();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule